// File: doc/BRIEF.md
# Whole-Method Instruction Cache

This block is an instruction store for a stack processor that keeps one complete method on chip rather than a set of independent lines. When the core calls a method or returns to one, it presents the method's word address in external memory and the method's length in words. If that method is already resident, the request completes at once. If it is not, a fill sequencer copies the whole method body into the on-chip array, starting at array word zero, while a busy output holds the core.

Between calls and returns, the core fetches bytecodes with a byte offset relative to the start of the method. The offset indexes the array directly. There is no tag compare, no address translation and no miss path on ordinary fetches. Misses can therefore only happen at call and return boundaries, which makes instruction timing between those points fixed.

A length of zero, or one larger than the array, is refused with an error flag. The resident method is left as it was.

Top module: `method_cache`

## Requirements
- R1: After reset, busy, hit, err and mem_req are 0 and no method is resident, so the first valid request is a miss.
- R2: A request with a length of 1..CAP_WORDS whose base differs from the resident base (or when nothing is resident) is a miss. busy rises the cycle after the request and stays high while the method is copied. With a memory that answers one cycle after each read, busy is high for exactly 2*len cycles.
- R3: A request whose base equals the resident base gives a one-cycle hit pulse the cycle after the request. busy stays 0 and no memory read is made.
- R4: A request with length 0 or greater than CAP_WORDS sets err the cycle after the request, starts no fill and leaves the resident method usable. err stays set until the next accepted request clears it.
- R5: fetch_byte returns, one cycle after fetch_off is applied, byte fetch_off%4 of method word fetch_off/4. Byte 0 is bits 7:0 and byte 3 is bits 31:24, little-endian.
- R6: Requests presented while busy is high are ignored.
- R7: A fill keeps at most one read outstanding. Each mem_req is a single-cycle pulse, and reads go in ascending order from base to base+len-1.
- R8: A miss replaces the resident method. A later request for the previous base misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Call/return request strobe |
| req_base | input | AW | Method start word address in external memory |
| req_len | input | LEN_W | Method length in 32-bit words |
| busy | output | 1 | Fill in progress; the core must stall |
| hit | output | 1 | One-cycle pulse: requested method was resident |
| err | output | 1 | Last accepted request had an illegal length |
| mem_req | output | 1 | External word read strobe |
| mem_addr | output | AW | External word read address |
| mem_rdata | input | 32 | External read data |
| mem_rvalid | input | 1 | External read data valid |
| fetch_off | input | IDX_W+2 | Method-relative byte offset |
| fetch_byte | output | 8 | Fetched bytecode byte, registered |

## Verification
Every response is registered once. The bench therefore drives inputs on the falling edge and samples hit, err, busy and fetch_byte on the next falling edge, which falls just after the single register stage. Fill length is measured by counting falling edges with busy high and comparing the count against 2*len. The bench memory answers each read exactly one cycle later and checks each read address against the next expected ascending address as it is served. Cases that should be ignored or refused are judged afterwards through later hits and fetched bytes.

// File: rtl/mcache_pkg.sv
package mcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fill_st_e;
endpackage

// File: rtl/mcache_ram.sv
module mcache_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        rd_q <= store[rd_idx];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/mcache_bytesel.sv
module mcache_bytesel (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  lane_in,
    input  logic [31:0] word_in,
    output logic [7:0]  byte_out
);
    logic [1:0] lane_d, lane_q;

    always_comb begin
        lane_d = lane_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= 2'd0;
        else        lane_q <= lane_d;
    end

    always_comb begin
        byte_out = word_in[8*lane_q +: 8];
    end
endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl
    import mcache_pkg::*;
#(
    parameter int AW        = 20,
    parameter int LEN_W     = 16,
    parameter int CAP_WORDS = 64,
    localparam int IW       = $clog2(CAP_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_base,
    input  logic [LEN_W-1:0] req_len,
    input  logic             mem_rvalid,
    output logic             busy,
    output logic             hit,
    output logic             err,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             wr_en,
    output logic [IW-1:0]    wr_idx
);
    localparam logic [LEN_W-1:0] CAP_L = LEN_W'(CAP_WORDS);

    typedef struct packed {
        fill_st_e         st;
        logic [AW-1:0]    base;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic             resident;
        logic             hit;
        logic             err;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d       = q;
        d.hit   = 1'b0;
        wr_en   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_len == '0 || req_len > CAP_L) begin
                        d.err = 1'b1;
                    end else begin
                        d.err = 1'b0;
                        if (q.resident && req_base == q.base) begin
                            d.hit = 1'b1;
                        end else begin
                            d.base     = req_base;
                            d.len      = req_len;
                            d.cnt      = '0;
                            d.resident = 1'b0;
                            d.st       = ST_ISSUE;
                        end
                    end
                end
            end
            ST_ISSUE: begin
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    wr_en = 1'b1;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt + 1'b1 == q.len) begin
                        d.st       = ST_IDLE;
                        d.resident = 1'b1;
                    end else begin
                        d.st = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.base     <= '0;
            q.len      <= '0;
            q.cnt      <= '0;
            q.resident <= 1'b0;
            q.hit      <= 1'b0;
            q.err      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign hit      = q.hit;
    assign err      = q.err;
    assign mem_req  = (q.st == ST_ISSUE);
    assign mem_addr = q.base + AW'(q.cnt);
    assign wr_idx   = q.cnt[IW-1:0];
endmodule

// File: rtl/method_cache.sv
module method_cache #(
    parameter int AW        = 20,
    parameter int LEN_W     = 16,
    parameter int CAP_WORDS = 64,
    localparam int IW       = $clog2(CAP_WORDS),
    localparam int OW       = IW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_base,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             hit,
    output logic             err,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_rvalid,
    input  logic [OW-1:0]    fetch_off,
    output logic [7:0]       fetch_byte
);
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [31:0]   rd_word;

    mcache_ctrl #(.AW(AW), .LEN_W(LEN_W), .CAP_WORDS(CAP_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_base(req_base), .req_len(req_len),
        .mem_rvalid(mem_rvalid),
        .busy(busy), .hit(hit), .err(err),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    mcache_ram #(.DEPTH(CAP_WORDS), .DW(32)) u_ram (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(mem_rdata),
        .rd_idx(fetch_off[OW-1:2]), .rd_data(rd_word)
    );

    mcache_bytesel u_sel (
        .clk(clk), .rst_n(rst_n), .lane_in(fetch_off[1:0]),
        .word_in(rd_word), .byte_out(fetch_byte)
    );
endmodule

// File: rtl/mcache_chk.sv
module mcache_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic hit,
    input logic err,
    input logic mem_req
);
    // R7: a read strobe never lasts two cycles
    a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R2: reads happen only during a fill
    a_r2_read_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R3: a hit never stalls
    a_r3_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !busy);
    // R4: refused length starts no fill
    a_r4_err_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R6: a fill starts only from a request
    a_r6_fill_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R3: hit and err never coincide
    a_r3_hit_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && err));
endmodule

bind method_cache mcache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .hit(hit), .err(err), .mem_req(mem_req)
);

// File: tb/method_cache_tb.sv
module method_cache_tb;
    localparam int AW = 20;
    localparam int LEN_W = 16;
    localparam int CAP = 64;
    localparam int OW = $clog2(CAP) + 2;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [AW-1:0] req_base = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic busy, hit, err, mem_req;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic mem_rvalid = 0;
    logic [OW-1:0] fetch_off = '0;
    logic [7:0] fetch_byte;

    int checks = 0, errors = 0, nreads = 0;
    logic [AW-1:0] exp_addr = '0;
    logic [AW-1:0] cur_base = '0;

    always #2 clk = ~clk;

    method_cache #(.AW(AW), .LEN_W(LEN_W), .CAP_WORDS(CAP)) u_dut (.*);

    function automatic logic [31:0] word_of(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'd3, 4'h0, a[19:16], a[7:0]} ^ {8'h00, a[15:8], 16'h0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: answers one cycle after each read, checks ascending order (R7)
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && mem_req) begin
            checks++;
            if (mem_addr !== exp_addr) begin
                errors++;
                $display("FAIL R7 read address actual=%0h expected=%0h", mem_addr, exp_addr);
            end
            exp_addr = exp_addr + 1'b1;
            nreads++;
            mem_rdata <= word_of(mem_addr);
            mem_rvalid <= 1'b1;
        end
    end

    task automatic do_req(input logic [AW-1:0] b, input int len,
                          input bit exp_hit, input bit exp_err, input string tag);
        int cyc;
        @(negedge clk);
        req_valid = 1; req_base = b; req_len = LEN_W'(len);
        nreads = 0; exp_addr = b;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " hit"}, 32'(hit), 32'(exp_hit));
        chk({tag, " err"}, 32'(err), 32'(exp_err));
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        chk({tag, " busy cycles"}, 32'(cyc), (exp_hit || exp_err) ? 32'd0 : 32'(2*len));
        chk({tag, " read count"}, 32'(nreads), (exp_hit || exp_err) ? 32'd0 : 32'(len));
        if (!exp_hit && !exp_err) cur_base = b;
    endtask

    task automatic do_fetch(input int off, input string tag);
        logic [31:0] w;
        @(negedge clk);
        fetch_off = OW'(off);
        @(negedge clk);
        w = word_of(cur_base + AW'(off / 4));
        chk({tag, " fetch byte"}, 32'(fetch_byte), 32'(w[8*(off%4) +: 8]));
    endtask

    localparam int NV = 9;
    localparam logic [AW-1:0] VB [NV] = '{20'h100, 20'h100, 20'h200, 20'h200, 20'h300,
                                          20'h200, 20'h300, 20'h100, 20'h200};
    localparam int VL [NV] = '{5, 5, 64, 64, 65, 64, 0, 1, 64};
    localparam bit VH [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 0};
    localparam bit VE [NV] = '{0, 0, 0, 0, 1, 0, 1, 0, 0};
    localparam string VT [NV] = '{"R1/R2", "R3", "R2", "R3", "R4", "R4", "R4", "R8", "R8"};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 hit", 32'(hit), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        for (int i = 0; i < NV; i++) begin
            do_req(VB[i], VL[i], VH[i], VE[i], VT[i]);
            if (!VE[i]) begin
                do_fetch(0, "R5");
                do_fetch(4 * VL[i] - 1, "R5");
            end else begin
                do_fetch(2, "R4 resident kept");
            end
        end

        // R5: sweep of byte lanes on the resident 64-word method
        for (int o = 0; o < 12; o++) do_fetch(o, "R5");
        do_fetch(4 * CAP - 2, "R5");

        // R6: request while busy is ignored
        @(negedge clk);
        req_valid = 1; req_base = 20'h400; req_len = 16'd8;
        nreads = 0; exp_addr = 20'h400;
        @(negedge clk);
        req_base = 20'h500; req_len = 16'd2;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 40 && busy; k++) @(negedge clk);
        chk("R6 reads of first request only", 32'(nreads), 32'd8);
        cur_base = 20'h400;
        do_req(20'h400, 8, 1, 0, "R6 original resident");
        do_fetch(29, "R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule